// File: doc/BRIEF.md
# I2C Slave Address and General-Call Monitor

This block watches an I2C bus from the slave-receive side. After every START it shifts in the next byte from the synchronised SDA level on each rising edge of the synchronised SCL level. It counts eight data bits and one acknowledge bit per byte, and it raises a one-cycle byte-complete pulse after the ninth bit. The upper seven bits of the first byte are compared with a programmed own address. The eighth bit is the direction bit and plays no part in the match. A first byte of all zeros is recognised as a general call.

Three status flags are kept:

- **Addressed flag.** In recognition mode it is set by an address match or by a general call. In the no-recognition mode it is set when the first data byte after the address byte completes. Any host read or write of the data buffer clears it.
- **General-call flag.** Only a START or a STOP on the bus clears it.
- **Last-bit flag.** It always holds the SDA level seen at the latest SCL rising edge. Right after a byte completes, this is the level of the acknowledge bit.

The block has no data stream at its edge. Every pin is a plain level or a plain pulse, and no valid/ready handshake applies.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset, `addressed`, `gen_call`, `last_bit` and `byte_done` are all 0.
- R2: With `addr_any`=0, the first byte after a START sets `addressed` at the cycle of `byte_done` when its bits 7..1 (MSB first on the wire) equal `own_addr`. Bit 0 (direction) is ignored.
- R3: A first byte of 8'h00 after a START sets `gen_call` at the `byte_done` cycle. With `addr_any`=0 it also sets `addressed`.
- R4: With `addr_any`=0, a nonzero first byte whose bits 7..1 differ from `own_addr` leaves `addressed` and `gen_call` at 0.
- R5: With `addr_any`=1, `addressed` is not set by the first byte. It is set at the `byte_done` of the second byte after the START (the first data byte), whatever the byte values. Later bytes do not set it.
- R6: A pulse on `buf_rd` or `buf_wr` clears `addressed` on the next cycle. If a set event falls in the same cycle, the set wins.
- R7: `gen_call` is cleared by `start_det` or `stop_det`. Buffer accesses do not change it.
- R8: `last_bit` equals the SDA level sampled at the most recent SCL rising edge. After a byte completes, it is the acknowledge bit.
- R9: `byte_done` is a one-cycle pulse one clock after every ninth SCL rising edge since the START. A START restarts the bit count.
- R10: Bytes after the first in a transfer never trigger an address match or a general call in recognition mode, even when they equal the address or zero.
- R11: SCL edges before the first START or after a STOP produce no `byte_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Synchronised SCL level |
| sda | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-cycle START condition pulse |
| stop_det | input | 1 | One-cycle STOP condition pulse |
| own_addr | input | ADDR_W | Programmed own slave address |
| addr_any | input | 1 | 1 = no address recognition, flag on first data byte |
| buf_rd | input | 1 | Host read strobe of the data buffer |
| buf_wr | input | 1 | Host write strobe of the data buffer |
| addressed | output | 1 | Addressed-as-slave flag |
| gen_call | output | 1 | General-call received flag |
| last_bit | output | 1 | SDA level at the latest SCL rising edge |
| byte_done | output | 1 | One-cycle pulse after the ninth bit of a byte |

## Verification
The hardest case to reach from the ports is a buffer access that falls in exactly the cycle in which a set event is taken. The bench makes it by raising `buf_rd` at the same falling clock edge at which it raises SCL for the acknowledge bit. Both then reach the register at the same rising edge.

The bench also sweeps all 256 first-byte values against four own addresses, covering address 0 and address 7'h7F. This reaches the general-call byte, both direction bits of every matching address, and every mismatch. Separate sequences cover the behaviour that depends on byte position: data bytes that repeat the address or zero, and the no-recognition mode that sets the flag only on the second byte.

// File: rtl/i2c_aw_pkg.sv
package i2c_aw_pkg;
  typedef enum logic [1:0] {
    POS_ADDR  = 2'd0,
    POS_DATA1 = 2'd1,
    POS_LATER = 2'd2
  } byte_pos_e;
endpackage

// File: rtl/aw_scl_edge.sv
module aw_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  output logic rise
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl;
  end

  assign rise = scl && !scl_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/aw_framer.sv
module aw_framer
  import i2c_aw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              sda,
  input  logic              start_det,
  input  logic              stop_det,
  output logic [DATA_W-1:0] rx_byte,
  output byte_pos_e         pos,
  output logic              frame_end,
  output logic              byte_done,
  output logic              last_bit
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt;
  logic             active;
  byte_pos_e        pos_next;

  assign frame_end = active && rise && !start_det && !stop_det && (cnt == LAST);

  always_comb begin
    case (pos)
      POS_ADDR:  pos_next = POS_DATA1;
      default:   pos_next = POS_LATER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active    <= 1'b0;
      pos       <= POS_ADDR;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      last_bit  <= 1'b0;
    end else begin
      byte_done <= frame_end;
      if (rise) last_bit <= sda;
      if (start_det) begin
        active <= 1'b1;
        cnt    <= '0;
        pos    <= POS_ADDR;
      end else if (stop_det) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active && rise) begin
        if (cnt == LAST) begin
          cnt <= '0;
          pos <= pos_next;
        end else begin
          cnt     <= cnt + 1'b1;
          rx_byte <= {rx_byte[DATA_W-2:0], sda};
        end
      end
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R8
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (last_bit == $past(sda)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !byte_done);
endmodule

// File: rtl/aw_flags.sv
module aw_flags
  import i2c_aw_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned DATA_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  byte_pos_e         pos,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_any,
  input  logic              buf_rd,
  input  logic              buf_wr,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              addressed,
  output logic              gen_call
);
  logic addr_hit, gc_hit, set_as, set_gc;

  assign addr_hit = (rx_byte[DATA_W-1:1] == own_addr);
  assign gc_hit   = (rx_byte == '0);
  assign set_as   = frame_end && (addr_any ? (pos == POS_DATA1)
                                           : ((pos == POS_ADDR) && (addr_hit || gc_hit)));
  assign set_gc   = frame_end && (pos == POS_ADDR) && gc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      gen_call  <= 1'b0;
    end else begin
      if (set_as)                addressed <= 1'b1;
      else if (buf_rd || buf_wr) addressed <= 1'b0;
      if (start_det || stop_det) gen_call <= 1'b0;
      else if (set_gc)           gen_call <= 1'b1;
    end
  end

  // R7
  gc_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !gen_call);
  // R7
  gc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_det && !stop_det && gen_call) |=> gen_call);
  // R6
  as_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((buf_rd || buf_wr) && !frame_end) |=> !addressed);
endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
  import i2c_aw_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_any,
  input  logic              buf_rd,
  input  logic              buf_wr,
  output logic              addressed,
  output logic              gen_call,
  output logic              last_bit,
  output logic              byte_done
);
  localparam int unsigned DATA_W = ADDR_W + 1;

  logic              rise, frame_end;
  logic [DATA_W-1:0] rx_byte;
  byte_pos_e         pos;

  aw_scl_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl(scl), .rise(rise)
  );

  aw_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .rise(rise), .sda(sda),
    .start_det(start_det), .stop_det(stop_det),
    .rx_byte(rx_byte), .pos(pos), .frame_end(frame_end),
    .byte_done(byte_done), .last_bit(last_bit)
  );

  aw_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .pos(pos),
    .rx_byte(rx_byte), .own_addr(own_addr), .addr_any(addr_any),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .start_det(start_det),
    .stop_det(stop_det), .addressed(addressed), .gen_call(gen_call)
  );

  // R2
  as_rise_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> byte_done);
  // R3
  gc_rise_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> byte_done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: tb/i2c_addr_watch_tb.sv
module i2c_addr_watch_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, start_det = 1'b0, stop_det = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic addr_any = 1'b0, buf_rd = 1'b0, buf_wr = 1'b0;
  logic addressed, gen_call, last_bit, byte_done;

  int checks = 0, errors = 0, done_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_addr_watch u_dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
    .addr_any(addr_any), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .addressed(addressed), .gen_call(gen_call), .last_bit(last_bit),
    .byte_done(byte_done)
  );

  always @(negedge clk) if (byte_done) done_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) buf_rd = 1'b1;
    @(negedge clk) buf_rd = 1'b0;
  endtask

  task automatic send_bit(input logic b, input logic clr);
    @(negedge clk) begin sda = b; scl = 1'b0; end
    repeat (2) @(negedge clk);
    scl = 1'b1; buf_rd = clr;
    @(negedge clk) buf_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack, input logic clr);
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0);
    send_bit(ack, clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    logic [6:0] addrs [4] = '{7'h00, 7'h2A, 7'h7F, 7'h51};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addressed", addressed, 0);
    check("R1 gen_call", gen_call, 0);
    check("R1 last_bit", last_bit, 0);
    check("R1 byte_done", byte_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 bits before any START
    d0 = done_cnt;
    send_byte(8'h54, 1'b1, 1'b0);
    check("R11 no byte_done before START", done_cnt - d0, 0);
    check("R8 last_bit tracks idle bits", last_bit, 1);

    // R2 R3 R4 R8 R9 sweep
    foreach (addrs[k]) begin
      own_addr = addrs[k];
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        bit exp_as, exp_gc;
        b = 8'(v);
        pulse_rd();
        pulse_start();
        check("R7 gen_call cleared by START", gen_call, 0);
        d0 = done_cnt;
        send_byte(b, b[0], 1'b0);
        exp_gc = (b == 8'h00);
        exp_as = exp_gc || (b[7:1] == own_addr);
        check(exp_gc ? "R3 addressed on general call" :
              (exp_as ? "R2 addressed on match" : "R4 no match"), addressed, int'(exp_as));
        check(exp_gc ? "R3 gen_call set" : "R4 gen_call clear", gen_call, int'(exp_gc));
        check("R9 one byte_done per byte", done_cnt - d0, 1);
        check("R8 last_bit is ack", last_bit, int'(b[0]));
      end
    end

    // R10 later bytes ignored in recognition mode
    own_addr = 7'h2A;
    pulse_rd();
    pulse_start();
    send_byte(8'h12, 1'b0, 1'b0);
    send_byte(8'h54, 1'b0, 1'b0);
    check("R10 data byte equal to address", addressed, 0);
    send_byte(8'h00, 1'b0, 1'b0);
    check("R10 zero data byte no gen_call", gen_call, 0);
    check("R10 zero data byte no addressed", addressed, 0);

    // R7 gen_call kept by buffer access, cleared by STOP
    pulse_start();
    send_byte(8'h00, 1'b0, 1'b0);
    pulse_rd();
    @(negedge clk) buf_wr = 1'b1;
    @(negedge clk) buf_wr = 1'b0;
    check("R7 gen_call survives buffer access", gen_call, 1);
    check("R6 buf_wr clears addressed", addressed, 0);
    pulse_stop();
    check("R7 gen_call cleared by STOP", gen_call, 0);

    // R11 after STOP
    d0 = done_cnt;
    send_byte(8'h54, 1'b0, 1'b0);
    check("R11 no byte_done after STOP", done_cnt - d0, 0);
    check("R11 no addressed after STOP", addressed, 0);

    // R9 START restarts bit count mid-byte
    pulse_start();
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    pulse_start();
    d0 = done_cnt;
    send_byte(8'h55, 1'b0, 1'b0);
    check("R9 restart after START", done_cnt - d0, 1);
    check("R2 match after restart", addressed, 1);

    // R6 set and clear in the same cycle
    pulse_rd();
    check("R6 buf_rd clears addressed", addressed, 0);
    pulse_start();
    send_byte(8'h54, 1'b1, 1'b1);
    check("R6 set wins over clear", addressed, 1);
    pulse_rd();

    // R5 no-recognition mode
    addr_any = 1'b1;
    pulse_start();
    send_byte(8'h54, 1'b0, 1'b0);
    check("R5 first byte does not set", addressed, 0);
    send_byte(8'hC3, 1'b0, 1'b0);
    check("R5 first data byte sets", addressed, 1);
    @(negedge clk) buf_wr = 1'b1;
    @(negedge clk) buf_wr = 1'b0;
    check("R6 buf_wr clears in mode 1", addressed, 0);
    send_byte(8'h3C, 1'b0, 1'b0);
    check("R5 later byte does not set", addressed, 0);
    pulse_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule